// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 12-bit control words from a host controller over a three-wire serial port (data, bit clock, latch) and turns them into parallel register outputs for an audio rate-conversion datapath. The three serial wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the bit clock and latch edges are then detected in the system clock domain.

Bits are shifted in on each rising edge of the serial bit clock. On a rising latch edge, the last 12 bits are decoded. The first of these bits is an address. A 0 selects the 11-bit attenuation register. A 1 selects the mode-flag register, which holds the test selects, the rate-check mode, the +12 dB gain flag, the de-emphasis sample-rate selects and the de-emphasis enable.

A control FSM tracks the frame and has three named states:
- `ST_COLLECT`: fewer than 12 bits held. A latch here discards the bits and stays in `ST_COLLECT`. The 12th bit moves the FSM to `ST_ARMED`.
- `ST_ARMED`: a full frame is held. Further bits keep shifting, so only the newest 12 count. A latch moves the FSM to `ST_COMMIT`.
- `ST_COMMIT`: one cycle that writes the addressed register and clears the bit count, then returns to `ST_COLLECT`.

When the serial-select input is low, the block works in pin-strap mode. De-emphasis enable and sample-rate selects come from dedicated pins, and the attenuation path reports unity gain.

Top module: `serial_ctrl_port`

## Requirements
- R1: Each data bit is sampled on a rising edge of `ser_clk`, and the first bit sent becomes the most significant bit of the frame.
- R2: A rising edge of `ser_lat` transfers the newest 12 received bits in parallel to the register that the first of them addresses.
- R3: A frame whose first bit is 0 loads its remaining 11 bits into `att_target` as an unsigned value, first-sent bit as MSB. Between writes, `att_target` holds its value.
- R4: A frame whose first bit is 1 loads the flags from its bits 6 to 12 (bit 1 is the first bit sent): bit 6 to `test_sel[0]`, bit 7 to `test_sel[1]`, bit 8 to `rate_mode`, bit 9 to `gain_boost`, bit 10 to `deemph_fs[0]`, bit 11 to `deemph_fs[1]`, bit 12 to `deemph_en`. Bits 2 to 5 have no effect.
- R5: `deemph_fs` is `{select2, select1}`: 00 means 44.1 kHz, 01 (select1 only) means 48 kHz, 10 (select2 only) means 32 kHz.
- R6: After reset, every flag output is 0, `att_target` is 400h and `att_update` is low.
- R7: While `serial_sel` is low:
  - `deemph_en` follows `pin_deemph_en`.
  - `deemph_fs` is `{pin_fs_b, pin_fs_a}`.
  - `att_target` reads 400h.
  - `gain_boost` reads 0.
- R8: A latch edge that arrives after fewer than 12 bits changes no register. When more than 12 bits arrive before the latch, only the last 12 are used.
- R9: `att_update` pulses high for exactly one cycle on each attenuation write, in the cycle the new value first appears, and never for a mode write.
- R10: Writing one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_lat | input | 1 | Serial latch (asynchronous) |
| serial_sel | input | 1 | 1: flags from serial port; 0: pin-strap mode |
| pin_deemph_en | input | 1 | De-emphasis enable pin for pin-strap mode |
| pin_fs_a | input | 1 | Sample-rate select 1 pin for pin-strap mode |
| pin_fs_b | input | 1 | Sample-rate select 2 pin for pin-strap mode |
| att_target | output | 11 | Attenuation target |
| att_update | output | 1 | One-cycle strobe on attenuation write |
| test_sel | output | 2 | Test mode select |
| rate_mode | output | 1 | Rate-check mode flag |
| gain_boost | output | 1 | +12 dB gain flag |
| deemph_fs | output | 2 | De-emphasis sample-rate select |
| deemph_en | output | 1 | De-emphasis enable |

## Verification
The hardest case to reach from the ports is a latch that lands while the FSM is in `ST_ARMED` and extra bits have pushed the oldest bits out of the frame. The decode must then use the newest 12 bits and not the first 12.

The bench builds this case with a 16-bit burst. The burst starts with four ones, so a stale first bit would misroute the write to the mode register. A short 11-bit burst is used for the opposite case, showing that the latch is dropped in `ST_COLLECT`.

Both cases are then confirmed at the outputs: the attenuation value and the strobe count are compared against the values expected after each burst.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_ARMED   = 2'd1,
        ST_COMMIT  = 2'd2
    } scr_state_e;

    typedef struct packed {
        logic [1:0] test_sel;
        logic       rate_mode;
        logic       gain_boost;
        logic [1:0] fs_sel;
        logic       deemph_en;
    } scr_mode_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int unsigned N_SIG  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] lvl
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
    parameter int unsigned FRAME_W = 12,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    input  logic               clear,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   count
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
            count <= '0;
        end else begin
            if (shift_en)
                frame <= {frame[FRAME_W-2:0], bit_in};
            if (clear)
                count <= '0;
            else if (shift_en && count != CNT_FULL)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/scr_ctrl_fsm.sv
module scr_ctrl_fsm
    import scr_pkg::*;
#(
    parameter int unsigned FRAME_W = 12,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_lvl,
    input  logic             lat_lvl,
    input  logic [CNT_W-1:0] count,
    output logic             shift_en,
    output logic             clear,
    output logic             commit,
    output scr_state_e       state
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    scr_state_e state_nx;
    logic       bclk_d, lat_d;
    logic       bit_rise, lat_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            lat_d  <= 1'b0;
        end else begin
            bclk_d <= bclk_lvl;
            lat_d  <= lat_lvl;
        end
    end

    assign bit_rise = bclk_lvl & ~bclk_d;
    assign lat_rise = lat_lvl & ~lat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: begin
                if (!lat_rise && bit_rise && count == CNT_LAST)
                    state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (lat_rise) state_nx = ST_COMMIT;
            end
            ST_COMMIT: state_nx = ST_COLLECT;
            default:   state_nx = ST_COLLECT;
        endcase
    end

    always_comb begin
        shift_en = bit_rise && (state != ST_COMMIT);
        clear    = (state == ST_COMMIT) || (state == ST_COLLECT && lat_rise);
        commit   = (state == ST_COMMIT);
    end
endmodule

// File: rtl/scr_regfile.sv
module scr_regfile
    import scr_pkg::*;
#(
    parameter int unsigned ATT_W   = 11,
    parameter int unsigned FRAME_W = ATT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    output logic [ATT_W-1:0]   att_q,
    output scr_mode_t          mode_q,
    output logic               att_wr
);
    localparam logic [ATT_W-1:0] ATT_UNITY = ATT_W'(1) << (ATT_W - 1);

    logic addr_mode;
    assign addr_mode = frame[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q  <= ATT_UNITY;
            mode_q <= '0;
            att_wr <= 1'b0;
        end else begin
            att_wr <= commit && !addr_mode;
            if (commit && !addr_mode)
                att_q <= frame[ATT_W-1:0];
            if (commit && addr_mode) begin
                mode_q.test_sel   <= {frame[5], frame[6]};
                mode_q.rate_mode  <= frame[4];
                mode_q.gain_boost <= frame[3];
                mode_q.fs_sel     <= {frame[1], frame[2]};
                mode_q.deemph_en  <= frame[0];
            end
        end
    end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
    import scr_pkg::*;
#(
    parameter int unsigned ATT_W     = 11,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_lat,
    input  logic             serial_sel,
    input  logic             pin_deemph_en,
    input  logic             pin_fs_a,
    input  logic             pin_fs_b,
    output logic [ATT_W-1:0] att_target,
    output logic             att_update,
    output logic [1:0]       test_sel,
    output logic             rate_mode,
    output logic             gain_boost,
    output logic [1:0]       deemph_fs,
    output logic             deemph_en
);
    localparam int unsigned FRAME_W = ATT_W + 1;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [ATT_W-1:0] ATT_UNITY = ATT_W'(1) << (ATT_W - 1);

    logic [2:0]         sync_lvl;
    logic               shift_en, clear, commit;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   count_w;
    scr_state_e         state_w;
    logic [ATT_W-1:0]   att_q;
    scr_mode_t          mode_q;

    scr_sync #(.N_SIG(3), .STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_lat, ser_clk, ser_dat}),
        .lvl   (sync_lvl)
    );

    scr_ctrl_fsm #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_lvl (sync_lvl[1]),
        .lat_lvl  (sync_lvl[2]),
        .count    (count_w),
        .shift_en (shift_en),
        .clear    (clear),
        .commit   (commit),
        .state    (state_w)
    );

    scr_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sync_lvl[0]),
        .clear    (clear),
        .frame    (frame),
        .count    (count_w)
    );

    scr_regfile #(.ATT_W(ATT_W), .FRAME_W(FRAME_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .frame  (frame),
        .att_q  (att_q),
        .mode_q (mode_q),
        .att_wr (att_update)
    );

    always_comb begin
        test_sel  = mode_q.test_sel;
        rate_mode = mode_q.rate_mode;
        if (serial_sel) begin
            att_target = att_q;
            gain_boost = mode_q.gain_boost;
            deemph_fs  = mode_q.fs_sel;
            deemph_en  = mode_q.deemph_en;
        end else begin
            att_target = ATT_UNITY;
            gain_boost = 1'b0;
            deemph_fs  = {pin_fs_b, pin_fs_a};
            deemph_en  = pin_deemph_en;
        end
    end
endmodule

// File: rtl/scr_checker.sv
module scr_checker
    import scr_pkg::*;
#(
    parameter int unsigned ATT_W = 11,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_lat,
    input logic             serial_sel,
    input logic [ATT_W-1:0] att_target,
    input logic             gain_boost,
    input logic             att_update,
    input scr_state_e       fsm_state,
    input logic [CNT_W-1:0] bit_count
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ATT_W + 1);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        att_update |=> !att_update);

    p_att_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_sel && $past(serial_sel) && !att_update) |-> $stable(att_target));

    p_latch_before_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        att_update |-> $past(ser_lat, 3));

    p_full_frame_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_COMMIT) |-> (bit_count == CNT_FULL));

    p_pin_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_sel |-> (att_target == (ATT_W'(1) << (ATT_W - 1)) && !gain_boost));
endmodule

bind serial_ctrl_port scr_checker #(.ATT_W(ATT_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_lat    (ser_lat),
    .serial_sel (serial_sel),
    .att_target (att_target),
    .gain_boost (gain_boost),
    .att_update (att_update),
    .fsm_state  (state_w),
    .bit_count  (count_w)
);

// File: tb/serial_ctrl_port_bench.sv
`timescale 1ns/1ps
module serial_ctrl_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic        serial_sel = 1'b1;
    logic        pin_deemph_en = 1'b0, pin_fs_a = 1'b0, pin_fs_b = 1'b0;
    logic [10:0] att_target;
    logic        att_update;
    logic [1:0]  test_sel;
    logic        rate_mode;
    logic        gain_boost;
    logic [1:0]  deemph_fs;
    logic        deemph_en;

    int total = 0;
    int bad   = 0;
    int strobes = 0;

    always #5 clk = ~clk;

    serial_ctrl_port u_serial_ctrl_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .serial_sel(serial_sel), .pin_deemph_en(pin_deemph_en),
        .pin_fs_a(pin_fs_a), .pin_fs_b(pin_fs_b), .att_target(att_target),
        .att_update(att_update), .test_sel(test_sel), .rate_mode(rate_mode),
        .gain_boost(gain_boost), .deemph_fs(deemph_fs), .deemph_en(deemph_en)
    );

    always @(negedge clk) if (att_update) strobes++;

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_dat = v[i];
            wait_clk(6);
            @(negedge clk); ser_clk = 1'b1;
            wait_clk(6);
            @(negedge clk); ser_clk = 1'b0;
        end
        wait_clk(4);
        @(negedge clk); ser_lat = 1'b1;
        wait_clk(6);
        @(negedge clk); ser_lat = 1'b0;
        wait_clk(12);
        @(negedge clk);
    endtask

    task automatic check_flags(string req, int ts, int rm, int gb, int fs, int de);
        check(req, "test_sel", test_sel, ts);
        check(req, "rate_mode", rate_mode, rm);
        check(req, "gain_boost", gain_boost, gb);
        check(req, "deemph_fs", deemph_fs, fs);
        check(req, "deemph_en", deemph_en, de);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R6", "att_target", att_target, 11'h400);
        check_flags("R6", 0, 0, 0, 0, 0);
        check("R6", "strobes", strobes, 0);
    endtask

    task automatic t_att_write();
        send_bits({20'd0, 1'b0, 11'h155}, 12);
        check("R3", "att_target", att_target, 11'h155);
        check("R9", "strobes", strobes, 1);
        check_flags("R10", 0, 0, 0, 0, 0);
        send_bits({20'd0, 1'b0, 11'h7FF}, 12);
        check("R1", "att_target", att_target, 11'h7FF);
        send_bits({20'd0, 1'b0, 11'h000}, 12);
        check("R3", "att_target zero", att_target, 11'h000);
        check("R9", "strobes", strobes, 3);
    endtask

    task automatic t_mode_write();
        send_bits(32'hD5D, 12);
        check_flags("R4", 2'b01, 1, 1, 2'b01, 1);
        check("R10", "att_target", att_target, 11'h000);
        check("R9", "no strobe on mode", strobes, 3);
        send_bits(32'hAdD, 12);
        check_flags("R4", 2'b01, 1, 1, 2'b01, 1);
    endtask

    task automatic t_fs_codes();
        send_bits(32'h802, 12);
        check_flags("R5", 0, 0, 0, 2'b10, 0);
        send_bits(32'h800, 12);
        check("R5", "deemph_fs 44k1", deemph_fs, 2'b00);
    endtask

    task automatic t_short_frame();
        send_bits({21'd0, 11'h3C3}, 11);
        check("R8", "short att", att_target, 11'h000);
        check("R8", "short strobes", strobes, 3);
    endtask

    task automatic t_long_frame();
        send_bits({16'd0, 4'hF, 1'b0, 11'h2AA}, 16);
        check("R8", "long att", att_target, 11'h2AA);
        check("R2", "long strobes", strobes, 4);
    endtask

    task automatic t_pin_mode();
        send_bits(32'h808, 12);
        check("R4", "gain_boost", gain_boost, 1);
        @(negedge clk);
        serial_sel = 1'b0; pin_deemph_en = 1'b1; pin_fs_a = 1'b0; pin_fs_b = 1'b1;
        @(negedge clk);
        check("R7", "att_target", att_target, 11'h400);
        check("R7", "gain_boost", gain_boost, 0);
        check("R7", "deemph_en", deemph_en, 1);
        check("R7", "deemph_fs", deemph_fs, 2'b10);
        pin_fs_a = 1'b1; pin_fs_b = 1'b0; pin_deemph_en = 1'b0;
        @(negedge clk);
        check("R7", "deemph_fs b", deemph_fs, 2'b01);
        check("R7", "deemph_en b", deemph_en, 0);
        serial_sel = 1'b1;
        @(negedge clk);
        check("R7", "att restored", att_target, 11'h2AA);
        check("R7", "boost restored", gain_boost, 1);
    endtask

    initial begin : watchdog
        wait_clk(150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        @(negedge clk); rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_att_write();
        t_mode_write();
        t_fs_codes();
        t_short_frame();
        t_long_frame();
        t_pin_mode();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule